// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank State Tracking

This block sits on the device side of a DDR SDRAM command interface. On every rising clock edge it samples the clock enable, the chip select, the three active-low command strobes (row strobe, column strobe and write enable), a 13-bit address and a 2-bit bank address. It turns them into one decoded command code. It also keeps, for each of four banks, whether the bank is idle or holds an open row, and which row is open.

A command that does not fit the state of the bank it targets raises a one-cycle error flag and changes no state. Address bit 10 has a different meaning for each command. On a column access (read or write) it asks for the bank to close by itself once the burst ends. Each bank counts its own burst, so the other banks keep taking commands while one bank is closing. On a precharge, bit 10 makes the command close every bank.

When the clock enable is sampled low, the internal clock stops for the next cycle. In that cycle nothing is decoded and no bank state moves. All outputs are registered and take their new value at the same edge that samples the command.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: While chip select is high at an active edge, the command reported is NOP (code 0) and no bank state changes, whatever the three strobes carry.
- R2: With chip select low, the strobes {ras_n,cas_n,we_n} decode as follows: 011 = ACTIVATE (code 1), 101 = READ (code 2), 100 = WRITE (code 3), 010 = PRECHARGE (code 4, or code 5 for all banks when addr bit 10 is high), 001 = REFRESH, 000 = MODE REGISTER SET (code 8). The pattern 110 reports NOP.
- R3: A REFRESH is reported as auto refresh (code 6) if the clock enable is high at that same edge, and as self-refresh entry (code 7) if it is low.
- R4: If the clock enable was sampled low at one edge, the next edge decodes nothing. At that edge cmd_o reads 0, err_o stays low, and bank open state, rows and auto-precharge countdowns hold.
- R5: ACTIVATE to an idle bank opens it and stores the 13-bit row from the address bus. cmd_bank_o reports the bank number for ACTIVATE, READ, WRITE and single-bank PRECHARGE.
- R6: ACTIVATE to a bank that is already open raises err_o for one cycle and leaves that bank's row unchanged.
- R7: READ or WRITE to an idle bank raises err_o and changes no bank state.
- R8: PRECHARGE with addr bit 10 low closes only the addressed bank. With bit 10 high it closes all banks. Either form clears pending auto-precharge on the banks it closes.
- R9: READ or WRITE with addr bit 10 high to an open bank sets that bank's pending flag. The bank closes, and the flag clears, at the BURST_CYC-th active edge after the command edge.
- R10: While one bank's auto-precharge is pending, the other banks accept commands normally. A pending flag is never set on an idle bank.
- R11: REFRESH of either kind while any bank is open raises err_o.
- R12: On a READ or WRITE, col_o captures the column: addr bits 9..0 in x8 mode, or addr bits 8..0 zero-extended in x16 mode. Between column commands col_o holds its value.
- R13: After reset all banks are idle, no pending flags are set, cmd_o is 0 and err_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | ROW_W (13) | Row / column address; bit 10 qualifies the command |
| bank_i | input | log2(NUM_BANKS) (2) | Bank address |
| cmd_o | output | 4 | Decoded command code of the last edge |
| cmd_bank_o | output | log2(NUM_BANKS) (2) | Bank of the last bank-addressed command |
| col_o | output | 10 | Column of the last READ/WRITE |
| err_o | output | 1 | Command at the last edge was illegal for the current state |
| bank_open_o | output | NUM_BANKS (4) | One bit per bank, high when a row is open |
| ap_pend_o | output | NUM_BANKS (4) | One bit per bank, high while auto-precharge is pending |
| open_rows_o | output | NUM_BANKS*ROW_W (52) | Open row of bank b in bits [b*ROW_W +: ROW_W] |

## Verification
Every strobe pattern is driven with chip select low, and the same patterns are driven again with chip select high. This separates real decoding from a decoder that ignores chip select. Commands are issued to open banks and to idle banks. This shows whether the legality check reads the addressed bank, and whether an illegal command really leaves the row and open bits alone. An auto-precharge read is overlapped with a write to a second bank, and the open bit is sampled one edge before and one edge at the expected close. This pins the countdown length exactly, and a wrong count on either side shows. Finally, clock enable is dropped around a precharge-all and a refresh. This tells a frozen cycle apart from one that decodes, and self-refresh entry apart from auto refresh.

// File: rtl/ddr_cmd_pkg.sv
// Shared command codes for the DDR command decoder and bank trackers.
package ddr_cmd_pkg;
    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_PREA = 4'd5,
        CMD_AREF = 4'd6,
        CMD_SREF = 4'd7,
        CMD_MRS  = 4'd8
    } cmd_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
// Combinational command decoder.
// Turns the sampled strobes into one command code. Assumes `active` is low
// in any cycle where the internal clock is stopped; such cycles decode as NOP.
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic active,
    input  logic cke_now,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd
);
    // Map strobe pattern plus qualifier bits onto a command code.
    always_comb begin
        cmd = CMD_NOP;
        if (active && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
                3'b001:  cmd = cke_now ? CMD_AREF : CMD_SREF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_track.sv
// State of one bank: open flag, open row, and the auto-precharge countdown.
// Assumes `sel` is high when the current command addresses this bank
// (or when the command is precharge-all). Assumes `cmd` is NOP when the clock is stopped.
module ddr_bank_track
    import ddr_cmd_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int BURST_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             sel,
    input  cmd_e             cmd,
    input  logic             a10,
    input  logic [ROW_W-1:0] row_i,
    output logic             is_open,
    output logic [ROW_W-1:0] row_o,
    output logic             ap_pend,
    output logic             bad
);
    localparam int CNT_W = $clog2(BURST_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic             is_col;
    logic             touch;

    // Classify the command against this bank's state.
    always_comb begin
        is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
        bad    = sel && ((is_col && !is_open) || (cmd == CMD_ACT && is_open));
        touch  = sel && ((is_col && is_open) || (cmd == CMD_ACT && !is_open)
                         || cmd == CMD_PRE || cmd == CMD_PREA);
    end

    // Update open state, row and the auto-precharge countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            row_o   <= '0;
            ap_pend <= 1'b0;
            cnt_q   <= '0;
        end else if (active) begin
            if (touch) begin
                if (cmd == CMD_ACT) begin
                    is_open <= 1'b1;
                    row_o   <= row_i;
                end else if (cmd == CMD_PRE || cmd == CMD_PREA) begin
                    is_open <= 1'b0;
                    ap_pend <= 1'b0;
                end else if (a10 || ap_pend) begin
                    ap_pend <= 1'b1;
                    cnt_q   <= CNT_LOAD;
                end
            end else if (ap_pend) begin
                if (cnt_q == CNT_W'(1)) begin
                    is_open <= 1'b0;
                    ap_pend <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ddr_cmd_tracker.sv
// Top level: samples the command bus, decodes it, tracks every bank and
// flags commands that are illegal for the current bank states.
// Assumes all inputs are synchronous to clk. Outputs are registered.
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter bit X16       = 1'b0,
    parameter int BURST_CYC = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke_i,
    input  logic                       cs_n_i,
    input  logic                       ras_n_i,
    input  logic                       cas_n_i,
    input  logic                       we_n_i,
    input  logic [ROW_W-1:0]           addr_i,
    input  logic [BA_W-1:0]            bank_i,
    output logic [3:0]                 cmd_o,
    output logic [BA_W-1:0]            cmd_bank_o,
    output logic [COL_W-1:0]           col_o,
    output logic                       err_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS-1:0]       ap_pend_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows_o
);
    localparam int AP_BIT = 10;

    logic                 cke_q;
    logic                 active;
    cmd_e                 cmd;
    logic [NUM_BANKS-1:0] bad_vec;
    logic                 refresh_bad;
    logic [COL_W-1:0]     col_next;

    // Remember the previous clock-enable sample; low stops the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke_i;
    end
    assign active = cke_q;

    ddr_cmd_decode u_dec (
        .active (active),
        .cke_now(cke_i),
        .cs_n   (cs_n_i),
        .ras_n  (ras_n_i),
        .cas_n  (cas_n_i),
        .we_n   (we_n_i),
        .a10    (addr_i[AP_BIT]),
        .cmd    (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (bank_i == BA_W'(b)) || (cmd == CMD_PREA);
        ddr_bank_track #(.ROW_W(ROW_W), .BURST_CYC(BURST_CYC)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (active),
            .sel    (sel),
            .cmd    (cmd),
            .a10    (addr_i[AP_BIT]),
            .row_i  (addr_i),
            .is_open(bank_open_o[b]),
            .row_o  (open_rows_o[b*ROW_W +: ROW_W]),
            .ap_pend(ap_pend_o[b]),
            .bad    (bad_vec[b])
        );
    end

    // Refresh legality and column extraction for the selected data width.
    always_comb begin
        refresh_bad = ((cmd == CMD_AREF) || (cmd == CMD_SREF)) && (|bank_open_o);
        if (X16) col_next = COL_W'(addr_i[COL_W-2:0]);
        else     col_next = addr_i[COL_W-1:0];
    end

    // Register the decoded command, its bank, column and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o      <= CMD_NOP;
            cmd_bank_o <= '0;
            col_o      <= '0;
            err_o      <= 1'b0;
        end else begin
            cmd_o <= cmd;
            err_o <= (|bad_vec) || refresh_bad;
            if (cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR || cmd == CMD_PRE)
                cmd_bank_o <= bank_i;
            if (cmd == CMD_RD || cmd == CMD_WR)
                col_o <= col_next;
        end
    end
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
// Property checker for ddr_cmd_tracker, attached by bind below.
module ddr_cmd_tracker_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BA_W      = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       active,
    input logic                       cke_i,
    input logic                       cs_n_i,
    input logic                       ras_n_i,
    input logic                       cas_n_i,
    input logic                       we_n_i,
    input logic [ROW_W-1:0]           addr_i,
    input logic [BA_W-1:0]            bank_i,
    input logic [3:0]                 cmd_o,
    input logic                       err_o,
    input logic [NUM_BANKS-1:0]       bank_open_o,
    input logic [NUM_BANKS-1:0]       ap_pend_o,
    input logic [NUM_BANKS*ROW_W-1:0] open_rows_o
);
    // R1
    cs_high_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cs_n_i) |=> (cmd_o == 4'd0 && !err_o));

    // R4
    stopped_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cmd_o == 4'd0 && !err_o));

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(bank_open_o) && $stable(open_rows_o) && $stable(ap_pend_o)));

    // R6
    act_open_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cs_n_i && {ras_n_i, cas_n_i, we_n_i} == 3'b011 && bank_open_o[bank_i])
        |=> (err_o && $stable(open_rows_o)));

    // R8
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cs_n_i && {ras_n_i, cas_n_i, we_n_i} == 3'b010 && addr_i[10])
        |=> (bank_open_o == '0 && ap_pend_o == '0));

    // R11
    refresh_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cs_n_i && {ras_n_i, cas_n_i, we_n_i} == 3'b001 && (|bank_open_o))
        |=> err_o);

    // R10
    pend_only_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_pend_o & ~bank_open_o) == '0);
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BA_W(BA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .cke_i(cke_i),
    .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .addr_i(addr_i), .bank_i(bank_i), .cmd_o(cmd_o), .err_o(err_o),
    .bank_open_o(bank_open_o), .ap_pend_o(ap_pend_o), .open_rows_o(open_rows_o)
);

// File: tb/sim_ddr_cmd_tracker.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_ddr_cmd_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_i = 1'b1, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic [12:0] addr_i = '0;
    logic [1:0]  bank_i = '0;
    logic [3:0]  cmd_o;
    logic [1:0]  cmd_bank_o;
    logic [9:0]  col_o;
    logic        err_o;
    logic [3:0]  bank_open_o, ap_pend_o;
    logic [51:0] open_rows_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ddr_cmd_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cs_n_i(cs_n_i),
        .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .addr_i(addr_i), .bank_i(bank_i), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
        .col_o(col_o), .err_o(err_o), .bank_open_o(bank_open_o),
        .ap_pend_o(ap_pend_o), .open_rows_o(open_rows_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one command (at a falling edge), then pass the next rising edge.
    task automatic issue(input logic cke, input logic cs, input logic [2:0] rcw,
                         input logic [12:0] a, input logic [1:0] ba);
        cke_i = cke; cs_n_i = cs; {ras_n_i, cas_n_i, we_n_i} = rcw;
        addr_i = a; bank_i = ba;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop(); issue(1'b1, 1'b0, 3'b111, 13'h0, 2'd0); endtask

    function automatic logic [12:0] row_of(input int b);
        return open_rows_o[b*ROW_W +: ROW_W];
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R13 open", bank_open_o, 4'b0000);
        check("R13 pend", ap_pend_o, 4'b0000);
        check("R13 cmd", cmd_o, 4'd0);
        check("R13 err", err_o, 1'b0);
    endtask

    task automatic t_cs_high();
        issue(1'b1, 1'b1, 3'b011, 13'h55, 2'd1);
        check("R1 act masked cmd", cmd_o, 4'd0);
        check("R1 act masked open", bank_open_o, 4'b0000);
        issue(1'b1, 1'b1, 3'b000, 13'h0, 2'd0);
        check("R1 mrs masked", cmd_o, 4'd0);
    endtask

    task automatic t_activate();
        issue(1'b1, 1'b0, 3'b011, 13'h0ABC, 2'd0);
        check("R2 act code", cmd_o, 4'd1);
        issue(1'b1, 1'b0, 3'b011, 13'h1FFF, 2'd3);
        check("R5 bank", cmd_bank_o, 2'd3);
        check("R5 open", bank_open_o, 4'b1001);
        check("R5 row0", row_of(0), 13'h0ABC);
        check("R5 row3", row_of(3), 13'h1FFF);
        check("R5 no err", err_o, 1'b0);
    endtask

    task automatic t_illegal();
        issue(1'b1, 1'b0, 3'b011, 13'h0005, 2'd0);
        check("R6 err", err_o, 1'b1);
        check("R6 row kept", row_of(0), 13'h0ABC);
        issue(1'b1, 1'b0, 3'b101, 13'h0010, 2'd1);
        check("R7 rd code", cmd_o, 4'd2);
        check("R7 err", err_o, 1'b1);
        check("R7 open", bank_open_o, 4'b1001);
        issue(1'b1, 1'b0, 3'b100, 13'h0010, 2'd3);
        check("R2 wr code", cmd_o, 4'd3);
        check("R7 legal wr", err_o, 1'b0);
        check("R7 no pend", ap_pend_o, 4'b0000);
        issue(1'b1, 1'b0, 3'b001, 13'h0, 2'd0);
        check("R3 aref code", cmd_o, 4'd6);
        check("R11 err", err_o, 1'b1);
        issue(1'b1, 1'b0, 3'b000, 13'h0031, 2'd0);
        check("R2 mrs code", cmd_o, 4'd8);
        check("R2 mrs no err", err_o, 1'b0);
        issue(1'b1, 1'b0, 3'b110, 13'h0, 2'd0);
        check("R2 110 nop", cmd_o, 4'd0);
        check("R2 state kept", bank_open_o, 4'b1001);
    endtask

    task automatic t_precharge();
        issue(1'b1, 1'b0, 3'b010, 13'h0000, 2'd3);
        check("R2 pre code", cmd_o, 4'd4);
        check("R8 single", bank_open_o, 4'b0001);
        issue(1'b1, 1'b0, 3'b011, 13'h0007, 2'd2);
        check("R8 reopen", bank_open_o, 4'b0101);
        issue(1'b1, 1'b0, 3'b010, 13'h0400, 2'd1);
        check("R2 prea code", cmd_o, 4'd5);
        check("R8 all", bank_open_o, 4'b0000);
    endtask

    task automatic t_autopre();
        issue(1'b1, 1'b0, 3'b011, 13'h0011, 2'd0);
        issue(1'b1, 1'b0, 3'b011, 13'h0022, 2'd1);
        issue(1'b1, 1'b0, 3'b101, 13'h0400, 2'd0);
        check("R9 pend set", ap_pend_o, 4'b0001);
        issue(1'b1, 1'b0, 3'b100, 13'h0003, 2'd1);
        check("R10 other bank ok", err_o, 1'b0);
        check("R10 pend kept", ap_pend_o, 4'b0001);
        nop();
        nop();
        check("R9 still open", bank_open_o, 4'b0011);
        nop();
        check("R9 closed", bank_open_o, 4'b0010);
        check("R9 pend cleared", ap_pend_o, 4'b0000);
        issue(1'b1, 1'b0, 3'b100, 13'h0400, 2'd1);
        check("R9 wr pend", ap_pend_o, 4'b0010);
        issue(1'b1, 1'b0, 3'b010, 13'h0000, 2'd1);
        check("R8 pre clears pend", ap_pend_o, 4'b0000);
        check("R8 pre closes", bank_open_o, 4'b0000);
    endtask

    task automatic t_cke();
        issue(1'b1, 1'b0, 3'b011, 13'h0009, 2'd2);
        issue(1'b0, 1'b0, 3'b111, 13'h0, 2'd0);
        check("R4 last active", bank_open_o, 4'b0100);
        issue(1'b0, 1'b0, 3'b010, 13'h0400, 2'd0);
        check("R4 frozen cmd", cmd_o, 4'd0);
        check("R4 frozen state", bank_open_o, 4'b0100);
        issue(1'b1, 1'b0, 3'b010, 13'h0400, 2'd0);
        check("R4 still frozen", bank_open_o, 4'b0100);
        issue(1'b1, 1'b0, 3'b010, 13'h0400, 2'd0);
        check("R4 resumed", bank_open_o, 4'b0000);
        issue(1'b0, 1'b0, 3'b001, 13'h0, 2'd0);
        check("R3 sref code", cmd_o, 4'd7);
        check("R11 idle ok", err_o, 1'b0);
        issue(1'b0, 1'b0, 3'b001, 13'h0, 2'd0);
        check("R4 sref held", cmd_o, 4'd0);
        issue(1'b1, 1'b1, 3'b111, 13'h0, 2'd0);
        issue(1'b1, 1'b0, 3'b001, 13'h0, 2'd0);
        check("R3 aref idle", cmd_o, 4'd6);
    endtask

    task automatic t_column();
        issue(1'b1, 1'b0, 3'b011, 13'h0001, 2'd0);
        issue(1'b1, 1'b0, 3'b101, 13'h1FFF, 2'd0);
        check("R12 col x8", col_o, 10'h3FF);
        issue(1'b1, 1'b0, 3'b011, 13'h0002, 2'd1);
        check("R12 col held", col_o, 10'h3FF);
        issue(1'b1, 1'b0, 3'b100, 13'h0123, 2'd1);
        check("R12 col wr", col_o, 10'h123);
        issue(1'b1, 1'b0, 3'b010, 13'h0400, 2'd0);
        check("R8 final close", bank_open_o, 4'b0000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_cs_high();
        t_activate();
        t_illegal();
        t_precharge();
        t_autopre();
        t_cke();
        t_column();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule